// File: doc/BRIEF.md
# Feedback-Paced Four-Rail Power Sequencer

This controller brings up four power rails, named A to D, one after another in the fixed order A, B, C, D and takes them down in the fixed order D, C, B, A. It has no inter-rail delay timers. Each step waits for a digital status bit from the analog front end. During turn-on this bit is a per-rail "gate close to full drive" flag. During turn-off it is a per-rail "gate under the low threshold" flag. The analog threshold detectors are outside the block. Their results arrive as plain synchronous bits.

Turn-on starts only after every undervoltage-good input, the enable request and the shared kill line have all been good for a qualification window. After the last rail reports full drive, a settle window runs. The active-low system hold output is then released high. An undervoltage loss on any rail while a sequence is active cuts all rails at once. It also pulls the hold output low and drives the shared kill line low, so that other sequencers on the same wire stop too. A low level on the incoming kill line cuts all rails in the same way. A watchdog raises a flag when one step waits too long for its feedback. Once the inputs qualify again, restart needs no outside action.

Top module: `rail_sequencer`

## Requirements
- R1: After reset, `rail_en` is 0, `sys_hold_n` is 0, `kill_out_n` is 1 and `stall` is 0.
- R2: Rail A (`rail_en` bit 0) asserts on the STABLE_CYC-th consecutive clock edge at which all `uv_ok` bits, `en_req` and `kill_in_n` are high. Any single low cycle restarts that count.
- R3: Bit i of `rail_en` maps to rail A+i. While rail i is the highest rail on during turn-on, rail i+1 asserts one cycle after `gate_full[i]` is sampled high. The `gate_full` bits of other rails have no effect.
- R4: `sys_hold_n` goes high exactly SETTLE_CYC cycles after the cycle in which `gate_full[3]` moved the sequence into its settle window. It is high only while all four rails are on.
- R5: If any `uv_ok` bit is low while a sequence is active (any state other than idle), then in the next cycle `rail_en` is 0, `sys_hold_n` is 0 and `kill_out_n` is 0. `kill_out_n` stays 0 until all `uv_ok` bits are high again.
- R6: A low `kill_in_n` clears `rail_en` and `sys_hold_n` in the next cycle. It never drives `kill_out_n` low by itself.
- R7: A low `en_req` during turn-on, the settle window or the on state works as follows. It drops `sys_hold_n` and the highest rail that is on in the next cycle. Each next lower rail drops one cycle after `gate_low` of the rail just turned off is sampled high. The `gate_low` bits of other rails have no effect.
- R8: A fault (R5) or kill (R6) in the same cycle as a turn-on advance, a settle expiry or a shutdown request wins: all rails are off in the next cycle.
- R9: `stall` goes high after WDOG_CYC cycles spent waiting at one turn-on or turn-off step. It returns low one cycle after that step advances.
- R10: After a fault, turn-on restarts by itself under R2 once the inputs qualify again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_ok | input | 4 | Per-rail undervoltage-good status, 1 = good |
| en_req | input | 1 | 1 requests rails on, 0 requests ordered shutdown |
| kill_in_n | input | 1 | Shared kill line level, 0 = kill |
| gate_full | input | 4 | Per-rail gate near full drive |
| gate_low | input | 4 | Per-rail gate below low threshold |
| rail_en | output | 4 | Rail enables, bit 0 = rail A |
| sys_hold_n | output | 1 | Active-low system hold, high = rails settled |
| kill_out_n | output | 1 | Kill line drive, 0 = pull line low |
| stall | output | 1 | A step has waited too long for feedback |

## Verification
The main collisions are a protective cut landing in the same cycle as a normal step, that is, a feedback advance or a shutdown request. The bench raises the next rail's `gate_full` together with an undervoltage drop, and separately drops `en_req` and `kill_in_n` together. It judges the result by seeing `rail_en` at zero in the next cycle rather than one rail more or one rail fewer. The bench also sweeps the undervoltage fault over every rail bit at every turn-on stage and in the on state. It expects a full cut and `kill_out_n` low each time.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RAMP   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_RUN    = 3'd3,
    ST_DOWN   = 3'd4
  } seq_st_t;

  // Count has reached the final value of a window of length lim.
  function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == (lim - 32'd1);
  endfunction

endpackage

// File: rtl/rseq_streak.sv
// Counts consecutive cycles of cond; done marks the LIM-th one.
module rseq_streak #(
  parameter int LIM = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic done
);
  localparam int W = (LIM < 2) ? 1 : $clog2(LIM + 1);

  logic [W-1:0] cnt;

  assign done = cond && rseq_pkg::at_limit(32'(cnt), 32'(LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!cond) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rseq_watchdog.sv
// Flags a step that waits LIM cycles without advancing.
module rseq_watchdog #(
  parameter int LIM = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  input  logic advance,
  output logic stall
);
  localparam int W = (LIM < 2) ? 1 : $clog2(LIM + 1);

  logic [W-1:0] cnt;
  logic         expire;

  assign expire = rseq_pkg::at_limit(32'(cnt), 32'(LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      stall <= 1'b0;
    end else if (!waiting || advance) begin
      cnt   <= '0;
      stall <= 1'b0;
    end else if (expire) begin
      stall <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int NRAIL      = 4,
  parameter int STABLE_CYC = 10000,
  parameter int SETTLE_CYC = 160000,
  parameter int WDOG_CYC   = 65535,
  parameter bit WDOG_EN    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NRAIL-1:0] uv_ok,
  input  logic             en_req,
  input  logic             kill_in_n,
  input  logic [NRAIL-1:0] gate_full,
  input  logic [NRAIL-1:0] gate_low,
  output logic [NRAIL-1:0] rail_en,
  output logic             sys_hold_n,
  output logic             kill_out_n,
  output logic             stall
);
  import rseq_pkg::*;

  localparam int IW = (NRAIL < 2) ? 1 : $clog2(NRAIL);
  localparam logic [IW-1:0] LAST = IW'(NRAIL - 1);

  seq_st_t          st;
  logic [IW-1:0]    idx;
  logic [NRAIL-1:0] mask;
  logic             uv_trip;

  // Named events
  logic qual, uv_bad, active, force_off;
  logic start_go, settle_done, up_adv, dn_adv, stop_req;
  logic waiting, advance;

  assign uv_bad    = !(&uv_ok);
  assign qual      = !uv_bad && en_req && kill_in_n;
  assign active    = (st != ST_IDLE);
  assign force_off = !kill_in_n || (active && uv_bad);
  assign up_adv    = (st == ST_RAMP) && gate_full[idx];
  assign dn_adv    = (st == ST_DOWN) && gate_low[idx];
  assign stop_req  = !en_req && ((st == ST_RAMP) || (st == ST_SETTLE) || (st == ST_RUN));
  assign waiting   = (st == ST_RAMP) || (st == ST_DOWN);
  assign advance   = up_adv || dn_adv || stop_req || force_off;

  rseq_streak #(.LIM(STABLE_CYC)) i_qual (
    .clk(clk), .rst_n(rst_n), .cond(qual && (st == ST_IDLE)), .done(start_go)
  );

  rseq_streak #(.LIM(SETTLE_CYC)) i_settle (
    .clk(clk), .rst_n(rst_n), .cond(st == ST_SETTLE), .done(settle_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      idx  <= '0;
      mask <= '0;
    end else if (force_off) begin
      st   <= ST_IDLE;
      idx  <= '0;
      mask <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_go) begin
          st      <= ST_RAMP;
          idx     <= '0;
          mask    <= '0;
          mask[0] <= 1'b1;
        end
        ST_RAMP: if (stop_req) begin
          st        <= ST_DOWN;
          mask[idx] <= 1'b0;
        end else if (up_adv) begin
          if (idx == LAST) st <= ST_SETTLE;
          else begin
            idx                <= idx + 1'b1;
            mask[idx + 1'b1]   <= 1'b1;
          end
        end
        ST_SETTLE: if (stop_req) begin
          st        <= ST_DOWN;
          mask[idx] <= 1'b0;
        end else if (settle_done) st <= ST_RUN;
        ST_RUN: if (stop_req) begin
          st        <= ST_DOWN;
          mask[idx] <= 1'b0;
        end
        ST_DOWN: if (dn_adv) begin
          if (idx == '0) st <= ST_IDLE;
          else begin
            idx              <= idx - 1'b1;
            mask[idx - 1'b1] <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Kill drive: set by an active-sequence undervoltage, held until all good.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       uv_trip <= 1'b0;
    else if (!uv_bad) uv_trip <= 1'b0;
    else if (active)  uv_trip <= 1'b1;
  end

  generate
    if (WDOG_EN) begin : g_wdog
      rseq_watchdog #(.LIM(WDOG_CYC)) i_wdog (
        .clk(clk), .rst_n(rst_n), .waiting(waiting), .advance(advance), .stall(stall)
      );
    end else begin : g_nowdog
      assign stall = 1'b0;
    end
  endgenerate

  assign rail_en    = mask;
  assign sys_hold_n = (st == ST_RUN);
  assign kill_out_n = !uv_trip;
endmodule

// File: rtl/rail_sequencer_chk.sv
module rail_sequencer_chk #(
  parameter int NRAIL = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NRAIL-1:0] uv_ok,
  input logic             kill_in_n,
  input logic [NRAIL-2:0] gate_full_lo,
  input logic [NRAIL-1:1] gate_low_hi,
  input logic [NRAIL-1:0] rail_en,
  input logic             sys_hold_n,
  input logic             kill_out_n,
  input logic             stall
);
  // R3: enabled rails always form a contiguous run from rail A
  assert_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rail_en + 1'b1) & rail_en) == '0);

  // R3/R7: rail count moves by at most one per cycle unless cut to zero
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rail_en == '0) ||
      (($countones(rail_en) <= $countones($past(rail_en)) + 1) &&
       ($countones($past(rail_en)) <= $countones(rail_en) + 1)));

  // R5: undervoltage with rails on cuts everything and drives the kill line
  assert_uv_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en != '0) && !(&uv_ok) |=> (rail_en == '0) && !sys_hold_n && !kill_out_n);

  // R6: incoming kill cuts rails and hold
  assert_kill_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !kill_in_n |=> (rail_en == '0) && !sys_hold_n);

  // R4: hold released only with every rail on
  assert_hold_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_hold_n |-> (&rail_en));

  // R9: a stalled step never coexists with released hold
  assert_stall_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !sys_hold_n);

  generate
    for (genvar i = 1; i < NRAIL; i++) begin : g_up
      // R3: a rail rises only after the previous rail reported full drive
      assert_rise_fb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[i]) |-> $past(gate_full_lo[i-1]));
    end
    for (genvar i = 0; i < NRAIL - 1; i++) begin : g_dn
      // R7: a normal drop follows low-threshold report of the rail above
      assert_fall_fb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_en[i]) && $past(kill_in_n) && $past(&uv_ok)
          |-> $past(gate_low_hi[i+1]) || !$past(rail_en[i+1]));
    end
  endgenerate
endmodule

bind rail_sequencer rail_sequencer_chk #(.NRAIL(NRAIL)) i_chk (
  .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .kill_in_n(kill_in_n),
  .gate_full_lo(gate_full[NRAIL-2:0]), .gate_low_hi(gate_low[NRAIL-1:1]),
  .rail_en(rail_en), .sys_hold_n(sys_hold_n), .kill_out_n(kill_out_n), .stall(stall)
);

// File: tb/test_rail_sequencer.sv
module test_rail_sequencer;
  localparam int STABLE = 6;
  localparam int SETTLE = 10;
  localparam int WDOG   = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] uv_ok = 4'h0;
  logic       en_req = 1'b0;
  logic       kill_in_n = 1'b1;
  logic [3:0] gate_full = 4'h0;
  logic [3:0] gate_low = 4'h0;
  logic [3:0] rail_en;
  logic       sys_hold_n, kill_out_n, stall;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rail_sequencer #(.NRAIL(4), .STABLE_CYC(STABLE), .SETTLE_CYC(SETTLE),
                   .WDOG_CYC(WDOG), .WDOG_EN(1'b1)) i_rail_sequencer (
    .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .en_req(en_req), .kill_in_n(kill_in_n),
    .gate_full(gate_full), .gate_low(gate_low), .rail_en(rail_en),
    .sys_hold_n(sys_hold_n), .kill_out_n(kill_out_n), .stall(stall)
  );

  function automatic logic [3:0] run_of(input int n);
    return 4'((1 << n) - 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Qualify and reach rail A on
  task automatic start_up();
    uv_ok = 4'hF; en_req = 1'b1; kill_in_n = 1'b1; gate_full = 4'h0; gate_low = 4'h0;
    step(STABLE - 1);
    chk("R2 not yet started", 32'(rail_en), 32'h0);
    step(1);
    chk("R2 rail A on", 32'(rail_en), 32'h1);
  endtask

  task automatic ramp_to(input int n);
    for (int i = 0; i < n; i++) begin
      gate_full[i] = 1'b1;
      step(1);
      chk("R3 next rail on", 32'(rail_en), 32'(run_of(i + 2)));
    end
  endtask

  task automatic to_idle();
    kill_in_n = 1'b0; gate_full = 4'h0; gate_low = 4'h0;
    step(1);
    chk("R6 kill clears", 32'(rail_en), 32'h0);
    chk("R6 kill no drive", 32'(kill_out_n), 32'h1);
    kill_in_n = 1'b1; en_req = 1'b0;
    step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(2);
    chk("R1 rails", 32'(rail_en), 32'h0);
    chk("R1 hold", 32'(sys_hold_n), 32'h0);
    chk("R1 kill", 32'(kill_out_n), 32'h1);
    chk("R1 stall", 32'(stall), 32'h0);
    rst_n = 1'b1;
    step(1);

    // R2: interrupted qualification restarts count
    uv_ok = 4'hF; en_req = 1'b1;
    step(STABLE - 1);
    en_req = 1'b0;
    step(1);
    chk("R2 interrupted", 32'(rail_en), 32'h0);
    start_up();

    // R3: wrong feedback ignored; R9 watchdog on waiting step
    gate_full = 4'b1110;
    step(WDOG - 1);
    chk("R3 foreign full ignored", 32'(rail_en), 32'h1);
    chk("R9 not yet stalled", 32'(stall), 32'h0);
    step(1);
    chk("R9 stalled", 32'(stall), 32'h1);
    gate_full = 4'b0001;
    step(1);
    chk("R9 stall cleared", 32'(stall), 32'h0);
    chk("R3 B on", 32'(rail_en), 32'h3);
    ramp_to(0);
    gate_full = 4'b0011; step(1);
    chk("R3 C on", 32'(rail_en), 32'h7);
    gate_full = 4'b0111; step(1);
    chk("R3 D on", 32'(rail_en), 32'hF);
    gate_full = 4'hF; step(1);
    step(SETTLE - 1);
    chk("R4 hold early", 32'(sys_hold_n), 32'h0);
    step(1);
    chk("R4 hold released", 32'(sys_hold_n), 32'h1);

    // R7 ordered shutdown
    en_req = 1'b0; gate_full = 4'h0;
    step(1);
    chk("R7 D off first", 32'(rail_en), 32'h7);
    chk("R7 hold drops", 32'(sys_hold_n), 32'h0);
    gate_low = 4'b0001;
    step(2);
    chk("R7 foreign low ignored", 32'(rail_en), 32'h7);
    gate_low = 4'b1000; step(1);
    chk("R7 C off", 32'(rail_en), 32'h3);
    gate_low = 4'b0100; step(1);
    chk("R7 B off", 32'(rail_en), 32'h1);
    gate_low = 4'b0010; step(1);
    chk("R7 A off", 32'(rail_en), 32'h0);
    gate_low = 4'b0001; step(2);
    chk("R7 stays idle", 32'(rail_en), 32'h0);
    chk("R7 kill idle", 32'(kill_out_n), 32'h1);

    // R5/R10 sweep: every rail bit at every stage
    for (int s = 0; s < 6; s++) begin
      for (int b = 0; b < 4; b++) begin
        start_up();
        ramp_to(s < 3 ? s : 3);
        if (s >= 4) begin
          gate_full = 4'hF; step(1);
          if (s == 5) begin
            step(SETTLE);
            chk("R4 hold in sweep", 32'(sys_hold_n), 32'h1);
          end
        end
        uv_ok[b] = 1'b0; gate_full = 4'h0;
        step(1);
        chk("R5 rails cut", 32'(rail_en), 32'h0);
        chk("R5 hold low", 32'(sys_hold_n), 32'h0);
        chk("R5 kill driven", 32'(kill_out_n), 32'h0);
        step(3);
        chk("R5 kill held", 32'(kill_out_n), 32'h0);
        uv_ok = 4'hF;
        step(1);
        chk("R5 kill released", 32'(kill_out_n), 32'h1);
        step(STABLE - 2);
        chk("R10 waits", 32'(rail_en), 32'h0);
        step(1);
        chk("R10 restarted", 32'(rail_en), 32'h1);
        to_idle();
      end
    end

    // R6 kill in on state
    start_up(); ramp_to(3); gate_full = 4'hF; step(SETTLE + 1);
    chk("R6 pre hold", 32'(sys_hold_n), 32'h1);
    to_idle();
    chk("R6 hold low", 32'(sys_hold_n), 32'h0);

    // R8 collisions
    start_up(); ramp_to(1);
    gate_full = 4'b0011; uv_ok[3] = 1'b0;
    step(1);
    chk("R8 fault beats advance", 32'(rail_en), 32'h0);
    uv_ok = 4'hF; to_idle();
    start_up(); ramp_to(3); gate_full = 4'hF; step(SETTLE + 1);
    en_req = 1'b0; kill_in_n = 1'b0;
    step(1);
    chk("R8 kill beats shutdown", 32'(rail_en), 32'h0);
    kill_in_n = 1'b1; step(1);
    start_up(); ramp_to(3); gate_full = 4'hF; step(1);
    step(SETTLE - 1);
    uv_ok[0] = 1'b0;
    step(1);
    chk("R8 fault beats settle", 32'(sys_hold_n), 32'h0);
    chk("R8 fault beats settle rails", 32'(rail_en), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule